// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block keeps a small table of forwarding entries, each keyed by a 48-bit MAC address and a 12-bit VLAN ID and carrying an entry type and a destination group index. Software drives it through three word registers. It loads the key into two data registers, then writes a command into an access register. The engine stays busy for a fixed number of cycles, applies the command to the table, and then clears the command field to zero. Software polls that field to learn that the command is complete.

Two commands act on the table. Learn adds an entry, updates one, or removes one. Get-next walks the table in slot order and copies each entry it finds back into the registers. A separate aging tick ages out dynamic entries in two steps: the first tick marks an entry as not recently seen, and the second removes it. Locked and multicast entries are never aged. The register port is a plain control interface with no back-pressure. While a command is running, the engine drops writes and aging ticks, and software is expected to poll before it writes again.

Top module: `mact_engine`

## Requirements
- R1: Address 0 reads back the VLAN ID in bits 27:16, MAC byte 0 in 15:8 and MAC byte 1 in 7:0. Address 1 holds MAC bytes 2..5 from bits 31:24 down to 7:0. Address 2 holds entry-valid in bit 11, entry type in bits 10:9, destination index in bits 8:3 and the command in bits 2:0. Address 3 and all unused bits read 0, and every register is 0 after reset.
- R2: A write of a non-zero command to address 2 while idle holds `busy` high for exactly CMD_CYCLES cycles. After that the command field reads 0 (idle).
- R3: While `busy` is high, register writes have no effect.
- R4: Learn (command 1) with entry-valid set updates the type and destination of an entry whose key matches. If no entry matches, it writes the key into the lowest free slot.
- R5: A learn with entry-valid set, a key that is not present and no free slot leaves the table unchanged and sets `overflow`. `overflow` then stays set until reset.
- R6: Learn with entry-valid clear removes the matching entry, and does nothing if there is no match.
- R7: Get-next (command 4) finds the first valid entry in slot order after the slot that matches the data-register key, or from slot 0 if the key is not present. It loads that entry's key into the data registers and its type and destination into the access register, with entry-valid set.
- R8: When get-next finds no further entry, entry-valid reads 0 and the data registers keep their value.
- R9: An aging tick clears the seen mark of each normal (type 0) entry that has it and removes each normal entry that lacks it. Learn sets the seen mark.
- R10: Entries of types 1 (locked), 2 and 3 (IPv4 and IPv6 multicast) are never removed by aging.
- R11: Aging ticks that arrive while `busy` is high are ignored.
- R12: Command codes other than 0, 1 and 4 occupy the engine for CMD_CYCLES cycles but change neither the table nor the data registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| age_tick | input | 1 | One-cycle aging request |
| busy | output | 1 | A command is in progress |
| overflow | output | 1 | Sticky flag: a learn found the table full |

## Verification
Directed sequences separate an in-place update from a fresh insert, a remove from a miss, a locked entry from a normal one under two aging ticks, and a get-next that starts from a present key from one that starts from an absent key. Filling the table past its depth shows that the lowest free slot is chosen and that the overflow flag is sticky. Writes and ticks issued in the middle of a command show that nothing leaks in while the engine is busy. A seeded random mix of learns, removals, ticks and get-next steps over a key pool larger than the table is then compared after every command with a slot-exact model, and the model's slot order is what exposes wrong free-slot or walk ordering.

// File: rtl/mact_pkg.sv
package mact_pkg;
  localparam int VID_W  = 12;
  localparam int MAC_W  = 48;
  localparam int KEY_W  = VID_W + MAC_W;
  localparam int DEST_W = 6;   // access bits 8:3

  localparam logic [2:0] CMD_IDLE  = 3'd0;
  localparam logic [2:0] CMD_LEARN = 3'd1;
  localparam logic [2:0] CMD_NEXT  = 3'd4;

  localparam logic [1:0] ET_NORMAL = 2'd0;

  typedef struct packed {
    logic              valid;
    logic              seen;
    logic [1:0]        etype;
    logic [DEST_W-1:0] dest;
    logic [KEY_W-1:0]  key;
  } slot_t;
endpackage

// File: rtl/mact_timer.sv
module mact_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (start && cnt == '0) cnt <= CW'(CYCLES);
    else if (cnt != '0)          cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R2
endmodule

// File: rtl/mact_store.sv
module mact_store
  import mact_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  key_in,
  input  logic              learn_en,
  input  logic              learn_valid,
  input  logic [1:0]        learn_type,
  input  logic [DEST_W-1:0] learn_dest,
  input  logic              age_en,
  output logic              hit,
  output logic              full,
  output logic              nxt_hit,
  output slot_t             nxt_ent
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  slot_t           tbl [DEPTH];
  logic [IW-1:0]   hidx, fidx, nidx;
  logic            free_hit;
  logic [DEPTH-1:0] valid_vec;

  always_comb begin
    hit = 1'b0; hidx = '0; free_hit = 1'b0; fidx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      valid_vec[i] = tbl[i].valid;
      if (!hit && tbl[i].valid && tbl[i].key == key_in) begin
        hit = 1'b1; hidx = IW'(i);
      end
      if (!free_hit && !tbl[i].valid) begin
        free_hit = 1'b1; fidx = IW'(i);
      end
    end
    full = !free_hit;
  end

  always_comb begin
    nxt_hit = 1'b0; nidx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!nxt_hit && tbl[i].valid && (!hit || IW'(i) > hidx)) begin
        nxt_hit = 1'b1; nidx = IW'(i);
      end
    end
    nxt_ent = tbl[nidx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (learn_en) begin
      if (learn_valid) begin
        if (hit) begin
          tbl[hidx].etype <= learn_type;
          tbl[hidx].dest  <= learn_dest;
          tbl[hidx].seen  <= 1'b1;
        end else if (free_hit) begin
          tbl[fidx] <= '{valid: 1'b1, seen: 1'b1, etype: learn_type,
                         dest: learn_dest, key: key_in};
        end
      end else if (hit) begin
        tbl[hidx].valid <= 1'b0;
      end
    end else if (age_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (tbl[i].valid && tbl[i].etype == ET_NORMAL) begin
          if (tbl[i].seen) tbl[i].seen  <= 1'b0;
          else             tbl[i].valid <= 1'b0;
        end
      end
    end
  end

  AST_QUIET_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !learn_en && !age_en |=> $stable(valid_vec)); // R11

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_LOCKED_NOT_AGED: assert property (@(posedge clk) disable iff (!rst_n)
      tbl[g].valid && tbl[g].etype != ET_NORMAL && !learn_en |=> tbl[g].valid); // R10
    AST_STALE_REMOVED: assert property (@(posedge clk) disable iff (!rst_n)
      age_en && !learn_en && tbl[g].valid && tbl[g].etype == ET_NORMAL && !tbl[g].seen
      |=> !tbl[g].valid); // R9
  end
endmodule

// File: rtl/mact_engine.sv
module mact_engine
  import mact_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CMD_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        age_tick,
  output logic        busy,
  output logic        overflow
);
  localparam int HI_W = VID_W + 16;

  logic [HI_W-1:0]   hi_q;
  logic [31:0]       lo_q;
  logic              acc_valid;
  logic [1:0]        acc_type;
  logic [DEST_W-1:0] acc_dest;
  logic [2:0]        acc_cmd;
  logic              ovf_q;

  logic wr_ok, start, done, learn_en, next_en, age_en;
  logic hit, full, nxt_hit;
  slot_t nxt_ent;
  logic [KEY_W-1:0] key;

  assign key      = {hi_q, lo_q};
  assign wr_ok    = reg_we && !busy;
  assign start    = wr_ok && reg_addr == 2'd2 && reg_wdata[2:0] != CMD_IDLE;
  assign learn_en = done && acc_cmd == CMD_LEARN;
  assign next_en  = done && acc_cmd == CMD_NEXT;
  assign age_en   = age_tick && !busy;

  mact_timer #(.CYCLES(CMD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  mact_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .key_in(key),
    .learn_en(learn_en), .learn_valid(acc_valid), .learn_type(acc_type),
    .learn_dest(acc_dest), .age_en(age_en),
    .hit(hit), .full(full), .nxt_hit(nxt_hit), .nxt_ent(nxt_ent)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0;
      acc_valid <= 1'b0; acc_type <= '0; acc_dest <= '0; acc_cmd <= CMD_IDLE;
      ovf_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          2'd0: hi_q <= reg_wdata[HI_W-1:0];
          2'd1: lo_q <= reg_wdata;
          2'd2: begin
            acc_valid <= reg_wdata[11];
            acc_type  <= reg_wdata[10:9];
            acc_dest  <= reg_wdata[8:3];
            acc_cmd   <= reg_wdata[2:0];
          end
          default: ;
        endcase
      end
      if (done) begin
        acc_cmd <= CMD_IDLE;
        if (next_en) begin
          if (nxt_hit) begin
            hi_q      <= nxt_ent.key[KEY_W-1:32];
            lo_q      <= nxt_ent.key[31:0];
            acc_valid <= 1'b1;
            acc_type  <= nxt_ent.etype;
            acc_dest  <= nxt_ent.dest;
          end else begin
            acc_valid <= 1'b0;
          end
        end
      end
      if (learn_en && acc_valid && !hit && full) ovf_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {{(32-HI_W){1'b0}}, hi_q};
      2'd1:    reg_rdata = lo_q;
      2'd2:    reg_rdata = {20'd0, acc_valid, acc_type, acc_dest, acc_cmd};
      default: reg_rdata = 32'd0;
    endcase
  end

  assign overflow = ovf_q;

  AST_CMD_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> acc_cmd == CMD_IDLE); // R2
  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && !done |=> $stable(hi_q) && $stable(lo_q) && $stable(acc_dest)
      && $stable(acc_type) && $stable(acc_valid)); // R3
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R5
  AST_MISS_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    next_en && !nxt_hit |=> $stable(hi_q) && $stable(lo_q)); // R8
endmodule

// File: tb/sim_mact_engine.sv
module sim_mact_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int CMD_CYCLES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        age_tick = 1'b0;
  logic        busy, overflow;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mact_engine #(.DEPTH(DEPTH), .CMD_CYCLES(CMD_CYCLES)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .age_tick(age_tick),
    .busy(busy), .overflow(overflow)
  );

  // model
  bit          m_valid [DEPTH];
  bit          m_seen  [DEPTH];
  logic [1:0]  m_type  [DEPTH];
  logic [5:0]  m_dest  [DEPTH];
  logic [59:0] m_key   [DEPTH];
  logic [27:0] m_hi = '0;
  logic [31:0] m_lo = '0;
  bit          m_av = 0;
  logic [1:0]  m_at = '0;
  logic [5:0]  m_ad = '0;
  bit          m_ovf = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_age();
    @(negedge clk); age_tick = 1'b1;
    @(negedge clk); age_tick = 1'b0;
  endtask

  function automatic int m_find(input logic [59:0] k);
    for (int i = 0; i < DEPTH; i++) if (m_valid[i] && m_key[i] == k) return i;
    return -1;
  endfunction

  function automatic void m_age();
    for (int i = 0; i < DEPTH; i++)
      if (m_valid[i] && m_type[i] == 2'd0) begin
        if (m_seen[i]) m_seen[i] = 0; else m_valid[i] = 0;
      end
  endfunction

  function automatic void m_exec(input logic [2:0] c);
    logic [59:0] k = {m_hi, m_lo};
    int h = m_find(k);
    int f = -1;
    if (c == 3'd1) begin
      if (m_av) begin
        if (h >= 0) begin m_type[h] = m_at; m_dest[h] = m_ad; m_seen[h] = 1; end
        else begin
          for (int i = DEPTH-1; i >= 0; i--) if (!m_valid[i]) f = i;
          if (f >= 0) begin
            m_valid[f] = 1; m_seen[f] = 1; m_type[f] = m_at; m_dest[f] = m_ad; m_key[f] = k;
          end else m_ovf = 1;
        end
      end else if (h >= 0) m_valid[h] = 0;
    end else if (c == 3'd4) begin
      for (int i = DEPTH-1; i > h; i--) if (m_valid[i]) f = i;
      if (f >= 0) begin
        m_hi = m_key[f][59:32]; m_lo = m_key[f][31:0];
        m_av = 1; m_at = m_type[f]; m_ad = m_dest[f];
      end else m_av = 0;
    end
  endfunction

  task automatic set_key(input logic [11:0] vid, input logic [47:0] mac);
    wr(2'd0, {4'd0, vid, mac[47:32]});
    wr(2'd1, mac[31:0]);
    m_hi = {vid, mac[47:32]}; m_lo = mac[31:0];
  endtask

  // issue a command, count busy cycles, update model, compare registers
  task automatic cmd(input string req, input bit v, input logic [1:0] t,
                     input logic [5:0] d, input logic [2:0] c);
    logic [31:0] r;
    int n = 0;
    wr(2'd2, {20'd0, v, t, d, c});
    m_av = v; m_at = t; m_ad = d;
    rd(2'd2, r);
    while (r[2:0] != 3'd0 && n < 100) begin
      n++; @(negedge clk); rd(2'd2, r);
    end
    chk("R2 busy cycles", 64'(n), 64'(CMD_CYCLES));
    chk("R2 busy low", 64'(busy), 64'd0);
    m_exec(c);
    chk({req, " access"}, 64'(r), 64'({20'd0, m_av, m_at, m_ad, 3'd0}));
    rd(2'd0, r); chk({req, " hi"}, 64'(r), 64'({4'd0, m_hi}));
    rd(2'd1, r); chk({req, " lo"}, 64'(r), 64'(m_lo));
    chk("R5 overflow", 64'(overflow), 64'(m_ovf));
  endtask

  task automatic learn(input logic [11:0] vid, input logic [47:0] mac,
                       input logic [1:0] t, input logic [5:0] d);
    set_key(vid, mac);
    cmd("R4 learn", 1'b1, t, d, 3'd1);
  endtask

  task automatic walk(input string req);
    set_key(12'hFFF, 48'hFFFF_FFFF_FFFF);
    for (int s = 0; s <= DEPTH; s++) begin
      cmd(req, 1'b0, 2'd0, 6'd0, 3'd4);
      if (!m_av) break;
    end
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240517));
    for (int i = 0; i < DEPTH; i++) begin
      m_valid[i] = 0; m_seen[i] = 0; m_type[i] = '0; m_dest[i] = '0; m_key[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and layout
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r); chk("R1 reset value", 64'(r), 64'd0);
    end
    chk("R1 reset overflow", 64'(overflow), 64'd0);
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, r); chk("R1 hi mask", 64'(r), 64'h0FFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, r); chk("R1 addr3", 64'(r), 64'd0);
    wr(2'd2, 32'hFFFF_FFF8); rd(2'd2, r); chk("R1 access mask", 64'(r), 64'h0000_0FF8);
    chk("R1 idle write no busy", 64'(busy), 64'd0);
    m_av = 1; m_at = 2'd3; m_ad = 6'h3F;

    // R4 insert and in-place update
    learn(12'd5, 48'h0011_2233_4455, 2'd1, 6'd5);
    learn(12'd6, 48'h00AA_BBCC_DDEE, 2'd0, 6'd7);
    learn(12'd6, 48'h00AA_BBCC_DDEE, 2'd2, 6'd9);
    walk("R7 walk");
    // R7 start from present key
    set_key(12'd5, 48'h0011_2233_4455);
    cmd("R7 from key", 1'b0, 2'd0, 6'd0, 3'd4);
    chk("R7 found second", 64'(m_hi), 64'({12'd6, 16'h00AA}));
    cmd("R8 end", 1'b0, 2'd0, 6'd0, 3'd4);
    chk("R8 valid clear", 64'(m_av), 64'd0);

    // R6 remove, and remove of absent key
    set_key(12'd6, 48'h00AA_BBCC_DDEE);
    cmd("R6 forget", 1'b0, 2'd0, 6'd0, 3'd1);
    set_key(12'd9, 48'h0000_0000_0009);
    cmd("R6 forget absent", 1'b0, 2'd0, 6'd0, 3'd1);
    walk("R6 walk");

    // R12 unsupported code
    set_key(12'd5, 48'h0011_2233_4455);
    cmd("R12 code3", 1'b1, 2'd0, 6'd1, 3'd3);
    walk("R12 walk");

    // R9/R10 aging
    learn(12'd7, 48'h0000_0000_0077, 2'd0, 6'd2);
    learn(12'd8, 48'h0000_0000_0088, 2'd3, 6'd3);
    pulse_age(); m_age();
    walk("R9 after one tick");
    pulse_age(); m_age();
    walk("R10 after two ticks");
    set_key(12'd7, 48'h0000_0000_0077);
    set_key(12'd4, 48'h0000_0000_0000);
    cmd("R9 removed", 1'b0, 2'd0, 6'd0, 3'd4);

    // R3 / R11 inputs during busy
    learn(12'd7, 48'h0000_0000_0077, 2'd0, 6'd2);
    pulse_age(); m_age();
    set_key(12'd1, 48'h0000_0000_0001);
    wr(2'd2, {20'd0, 1'b1, 2'd1, 6'd4, 3'd1});
    m_av = 1; m_at = 2'd1; m_ad = 6'd4;
    wr(2'd0, 32'h0ABC_DEF0);
    @(negedge clk); age_tick = 1'b1; @(negedge clk); age_tick = 1'b0;
    repeat (CMD_CYCLES + 2) @(negedge clk);
    m_exec(3'd1);
    rd(2'd0, r); chk("R3 hi unchanged", 64'(r), 64'({4'd0, m_hi}));
    rd(2'd2, r); chk("R3 access", 64'(r), 64'({20'd0, m_av, m_at, m_ad, 3'd0}));
    walk("R11 walk");

    // R5 fill and overflow
    for (int i = 0; i < DEPTH + 2; i++)
      learn(12'h700 + 12'(i), 48'h0200_0000_0100 + 48'(i), 2'd0, 6'(i));
    chk("R5 overflow set", 64'(overflow), 64'd1);
    walk("R5 walk");
    pulse_age(); m_age(); pulse_age(); m_age();
    walk("R9 drained");
    chk("R5 sticky", 64'(overflow), 64'd1);

    // random phase
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom % 10);
      int idx = int'($urandom % 24);
      logic [11:0] vid = 12'(idx % 3 + 1);
      logic [47:0] mac = 48'h0200_0000_0000 | 48'(idx);
      logic [1:0] t = ($urandom % 2 == 0) ? 2'd0 : 2'($urandom % 4);
      if (op < 5) learn(vid, mac, t, 6'($urandom % 64));
      else if (op == 5) begin set_key(vid, mac); cmd("R6 rand", 1'b0, 2'd0, 6'd0, 3'd1); end
      else if (op == 6) begin pulse_age(); m_age(); end
      else begin set_key(vid, mac); cmd("R7 rand", 1'b0, 2'd0, 6'd0, 3'd4); end
    end
    walk("R7 final walk");
    summary();
  end
endmodule